// File: doc/BRIEF.md
# Programmable LCD Panel Timing Generator

This block produces the raster timing for a TFT panel. A peripheral clock is divided down to a pixel rate, and two counters step through each line and each frame in a fixed order: active area, front porch, sync pulse, back porch. The block drives line sync, frame sync, data enable and a pixel clock. Each of these has its own polarity control. It also reports the pixel position in the active area, so that a separate fetch engine can supply the pixel data.

Software sets the block up through a small 32-bit register port. The block has no run bit. It produces timing whenever the pixel-clock enable input is high and reset is released. Software therefore writes the geometry while that input is low and raises it once setup is done. At the end of every frame the block sets a status bit. An enable bit decides whether that status reaches the interrupt line.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset, the size register at 0x04 reads 0x0040_0040 (64 by 64) and every other register reads 0. With the pixel-clock enable low, all timing outputs are 0, the coordinates are 0 and the interrupt is 0.
- R2: Writes to 0x04 (size), 0x18 (panel), 0x1C (horizontal), 0x20 (vertical) and 0x3C (interrupt enable) are stored in full and read back unchanged. Reading any unmapped offset returns 0.
- R3: The pixel period is N = panel[5:0]+1 peripheral clocks. Within each period the raw pixel clock is active in the phases at or above floor(N/2), counting phases from 0. With N = 1 it stays active.
- R4: Active width is 16 × size[25:20] pixels. A line is the active width, then a front porch of horizontal[15:8]+1 pixels, then line sync for horizontal[31:26]+1 pixels, then a back porch of horizontal[7:0]+3 pixels.
- R5: Active height is size[9:0] lines. A frame is the active lines, then vertical[15:8] front-porch lines, then frame sync for vertical[31:26] lines, then vertical[7:0] back-porch lines. No offsets are added to the vertical fields.
- R6: Data enable is active only inside both active ranges. While it is active, the x and y outputs give the pixel column and row. While it is inactive, both outputs are 0.
- R7: In the panel register, bit 20 inverts data enable, bit 21 inverts the pixel clock, bit 22 inverts line sync and bit 23 inverts frame sync. A set bit makes that signal active-low.
- R8: Bit 1 of the status register at 0x40 is set when the last pixel of the last active line finishes. Writing a 1 to that bit clears it. If a clear arrives in the same cycle as a set, the set wins.
- R9: The interrupt output is the status bit 1 ANDed with bit 1 of the enable register at 0x3C.
- R10: While the pixel-clock enable is low, the divider, pixel counter and line counter are held at 0, and every timing output sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; low holds the timing idle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| pclk_o | output | 1 | Pixel clock, after polarity |
| lsync_o | output | 1 | Line sync, after polarity |
| fsync_o | output | 1 | Frame sync, after polarity |
| de_o | output | 1 | Data enable, after polarity |
| pix_x | output | 12 | Active-area column |
| pix_y | output | 12 | Active-area row |
| irq_o | output | 1 | End-of-frame interrupt |

## Verification
The hardest case to reach from the ports is a write-one-to-clear of the end-of-frame bit in the same peripheral-clock cycle as a new frame end. That event comes only once per several thousand cycles, and only on the divider's final phase. The bench follows its own frame model and watches for the cycle just before the model predicts the final tick of the last active line. It places the clear write exactly there, then reads back the status and the interrupt. Three geometries are run, with dividers of 1, 2 and 3 and with inverted and normal polarities. Each one compares every output against the model on every clock.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          pclk_o,
  output logic          lsync_o,
  output logic          fsync_o,
  output logic          de_o,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic          irq_o
);
  localparam logic [AW-1:0] A_SIZE = AW'(8'h04);
  localparam logic [AW-1:0] A_PANL = AW'(8'h18);
  localparam logic [AW-1:0] A_HOR  = AW'(8'h1C);
  localparam logic [AW-1:0] A_VER  = AW'(8'h20);
  localparam logic [AW-1:0] A_IEN  = AW'(8'h3C);
  localparam logic [AW-1:0] A_STAT = AW'(8'h40);
  localparam logic [DW-1:0] SIZE_RST = DW'(32'h0040_0040);

  logic [DW-1:0] size_q, pcfg_q, hcfg_q, vcfg_q, ien_q;
  logic          eof_q;
  logic [5:0]    div_cnt;
  logic [CW-1:0] h_cnt, v_cnt;

  logic [CW-1:0] h_act, h_fpe, h_sye, h_tot;
  logic [CW-1:0] v_act, v_fpe, v_sye, v_tot;
  assign h_act = CW'({size_q[25:20], 4'b0000});
  assign h_fpe = h_act + CW'(hcfg_q[15:8]) + CW'(1);
  assign h_sye = h_fpe + CW'(hcfg_q[31:26]) + CW'(1);
  assign h_tot = h_sye + CW'(hcfg_q[7:0]) + CW'(3);
  assign v_act = CW'(size_q[9:0]);
  assign v_fpe = v_act + CW'(vcfg_q[15:8]);
  assign v_sye = v_fpe + CW'(vcfg_q[31:26]);
  assign v_tot = v_sye + CW'(vcfg_q[7:0]);

  logic [6:0] div_n;
  logic       tick, h_last, v_last, eof_set, clr_req;
  assign div_n   = {1'b0, pcfg_q[5:0]} + 7'd1;
  assign tick    = pix_en && (div_cnt == pcfg_q[5:0]);
  assign h_last  = (h_cnt == h_tot - CW'(1));
  assign v_last  = (v_cnt == v_tot - CW'(1));
  assign eof_set = tick && h_last && (v_cnt == v_act - CW'(1));
  assign clr_req = reg_wr && (reg_addr == A_STAT) && reg_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SIZE_RST;
      pcfg_q <= '0;
      hcfg_q <= '0;
      vcfg_q <= '0;
      ien_q  <= '0;
      eof_q  <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_SIZE:  size_q <= reg_wdata;
          A_PANL:  pcfg_q <= reg_wdata;
          A_HOR:   hcfg_q <= reg_wdata;
          A_VER:   vcfg_q <= reg_wdata;
          A_IEN:   ien_q  <= reg_wdata;
          default: ;
        endcase
      end
      if (eof_set)      eof_q <= 1'b1;
      else if (clr_req) eof_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      h_cnt   <= '0;
      v_cnt   <= '0;
    end else if (!pix_en) begin
      div_cnt <= '0;
      h_cnt   <= '0;
      v_cnt   <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      if (h_last) begin
        h_cnt <= '0;
        v_cnt <= v_last ? '0 : v_cnt + CW'(1);
      end else begin
        h_cnt <= h_cnt + CW'(1);
      end
    end else begin
      div_cnt <= div_cnt + 6'd1;
    end
  end

  always_comb begin
    case (reg_addr)
      A_SIZE:  reg_rdata = size_q;
      A_PANL:  reg_rdata = pcfg_q;
      A_HOR:   reg_rdata = hcfg_q;
      A_VER:   reg_rdata = vcfg_q;
      A_IEN:   reg_rdata = ien_q;
      A_STAT:  reg_rdata = DW'({eof_q, 1'b0});
      default: reg_rdata = '0;
    endcase
  end

  logic de_raw, ls_raw, fs_raw, pc_raw;
  assign de_raw = pix_en && (h_cnt < h_act) && (v_cnt < v_act);
  assign ls_raw = pix_en && (h_cnt >= h_fpe) && (h_cnt < h_sye);
  assign fs_raw = pix_en && (v_cnt >= v_fpe) && (v_cnt < v_sye);
  assign pc_raw = pix_en && (div_cnt >= div_n[6:1]);

  assign de_o    = de_raw ^ pcfg_q[20];
  assign pclk_o  = pc_raw ^ pcfg_q[21];
  assign lsync_o = ls_raw ^ pcfg_q[22];
  assign fsync_o = fs_raw ^ pcfg_q[23];
  assign pix_x   = de_raw ? h_cnt : '0;
  assign pix_y   = de_raw ? v_cnt : '0;
  assign irq_o   = eof_q && ien_q[1];
endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic          de_o,
  input logic          pclk_o,
  input logic          lsync_o,
  input logic          fsync_o,
  input logic          irq_o,
  input logic [CW-1:0] pix_x,
  input logic [CW-1:0] h_cnt,
  input logic [CW-1:0] v_cnt,
  input logic [5:0]    w_units,
  input logic [3:0]    pol,
  input logic          ien_bit
);
  // R10
  idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |-> (de_o == pol[0] && pclk_o == pol[1] && lsync_o == pol[2] && fsync_o == pol[3]));

  // R10
  idle_counters_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> (h_cnt == '0 && v_cnt == '0));

  // R4
  de_sync_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de_o != pol[0]) |-> (lsync_o == pol[2] && fsync_o == pol[3]));

  // R6
  x_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de_o != pol[0]) |-> (pix_x < CW'({w_units, 4'b0000})));

  // R9
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ien_bit);
endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .de_o(de_o), .pclk_o(pclk_o),
  .lsync_o(lsync_o), .fsync_o(fsync_o), .irq_o(irq_o), .pix_x(pix_x),
  .h_cnt(h_cnt), .v_cnt(v_cnt), .w_units(size_q[25:20]), .pol(pcfg_q[23:20]),
  .ien_bit(ien_q[1])
);

// File: tb/sim_lcd_timing_gen.sv
module sim_lcd_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        pclk_o, lsync_o, fsync_o, de_o, irq_o;
  logic [11:0] pix_x, pix_y;

  int checks = 0;
  int fails = 0;
  bit run = 1'b0;

  logic [31:0] s_size = 32'h0040_0040, s_pcfg = 32'h0, s_h = 32'h0, s_v = 32'h0, s_ien = 32'h0;
  int mdiv, mh, mv;
  bit meof, mset;

  always #2 clk = ~clk;

  lcd_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pclk_o(pclk_o), .lsync_o(lsync_o),
    .fsync_o(fsync_o), .de_o(de_o), .pix_x(pix_x), .pix_y(pix_y), .irq_o(irq_o)
  );

  function automatic int f_pcd();  return int'(s_pcfg[5:0]); endfunction
  function automatic int f_hact(); return 16 * int'(s_size[25:20]); endfunction
  function automatic int f_hfp();  return int'(s_h[15:8]) + 1; endfunction
  function automatic int f_hsw();  return int'(s_h[31:26]) + 1; endfunction
  function automatic int f_htot(); return f_hact() + f_hfp() + f_hsw() + int'(s_h[7:0]) + 3; endfunction
  function automatic int f_vact(); return int'(s_size[9:0]); endfunction
  function automatic int f_vtot(); return f_vact() + int'(s_v[15:8]) + int'(s_v[31:26]) + int'(s_v[7:0]); endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mdiv = 0; mh = 0; mv = 0; meof = 0;
    end else begin
      mset = 0;
      if (!pix_en) begin
        mdiv = 0; mh = 0; mv = 0;
      end else if (mdiv == f_pcd()) begin
        mset = (mh == f_htot() - 1) && (mv == f_vact() - 1);
        mdiv = 0;
        if (mh == f_htot() - 1) begin
          mh = 0;
          if (mv == f_vtot() - 1) mv = 0; else mv++;
        end else mh++;
      end else mdiv++;
      if (mset) meof = 1;
      else if (reg_wr && reg_addr == 8'h40 && reg_wdata[1]) meof = 0;
    end
  end

  always @(negedge clk) begin
    if (run) begin
      bit de, ls, fs, pc;
      int vfpe;
      vfpe = f_vact() + int'(s_v[15:8]);
      de = pix_en && mh < f_hact() && mv < f_vact();
      ls = pix_en && mh >= f_hact() + f_hfp() && mh < f_hact() + f_hfp() + f_hsw();
      fs = pix_en && mv >= vfpe && mv < vfpe + int'(s_v[31:26]);
      pc = pix_en && mdiv >= (f_pcd() + 1) / 2;
      check(de_o == (de ^ s_pcfg[20]), "R6/R7 data enable", 32'(de_o), 32'(de ^ s_pcfg[20]));
      check(pclk_o == (pc ^ s_pcfg[21]), "R3/R7 pixel clock", 32'(pclk_o), 32'(pc ^ s_pcfg[21]));
      check(lsync_o == (ls ^ s_pcfg[22]), "R4/R7 line sync", 32'(lsync_o), 32'(ls ^ s_pcfg[22]));
      check(fsync_o == (fs ^ s_pcfg[23]), "R5/R7 frame sync", 32'(fsync_o), 32'(fs ^ s_pcfg[23]));
      check(pix_x == (de ? 12'(mh) : 12'd0), "R6 x", 32'(pix_x), de ? 32'(mh) : 32'd0);
      check(pix_y == (de ? 12'(mv) : 12'd0), "R6 y", 32'(pix_y), de ? 32'(mv) : 32'd0);
      check(irq_o == (meof && s_ien[1]), "R9 irq", 32'(irq_o), 32'(meof && s_ien[1]));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    case (a)
      8'h04: s_size = d;
      8'h18: s_pcfg = d;
      8'h1C: s_h = d;
      8'h20: s_v = d;
      8'h3C: s_ien = d;
      default: ;
    endcase
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    check(reg_rdata === exp, req, reg_rdata, exp);
  endtask

  task automatic set_en(input bit v);
    @(posedge clk); #1 pix_en = v;
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    check({de_o, pclk_o, lsync_o, fsync_o} == {s_pcfg[20], s_pcfg[21], s_pcfg[22], s_pcfg[23]},
          req, 32'({de_o, pclk_o, lsync_o, fsync_o}),
          32'({s_pcfg[20], s_pcfg[21], s_pcfg[22], s_pcfg[23]}));
    check(pix_x == 0 && pix_y == 0, req, 32'({pix_x, pix_y}), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    run = 1'b1;
    // R1 reset state
    idle_check("R1 outputs after reset");
    rd(8'h04, 32'h0040_0040, "R1 size reset");
    rd(8'h18, 32'h0, "R1 panel reset");
    rd(8'h3C, 32'h0, "R1 enable reset");
    rd(8'h40, 32'h0, "R1 status reset");

    // Scenario A: 64x64, divide by 1
    wr(8'h04, (32'd4 << 20) | 32'd64);
    wr(8'h1C, (32'd1 << 26) | (32'd2 << 8) | 32'd0);
    wr(8'h20, (32'd2 << 26) | (32'd1 << 8) | 32'd2);
    wr(8'h18, 32'h0000_0000);
    rd(8'h1C, (32'd1 << 26) | (32'd2 << 8), "R2 horizontal readback");
    rd(8'h20, (32'd2 << 26) | (32'd1 << 8) | 32'd2, "R2 vertical readback");
    rd(8'h08, 32'h0, "R2 unmapped read");
    set_en(1'b1);
    repeat (11000) @(posedge clk);
    set_en(1'b0);
    // R10 idle after drop
    idle_check("R10 idle after enable drop");
    rd(8'h40, 32'h2, "R8 status set after frame");
    wr(8'h40, 32'h2);
    rd(8'h40, 32'h0, "R8 write-one clears");

    // Scenario B: 80x64, divide by 3, all polarities inverted
    wr(8'h04, (32'd5 << 20) | 32'd64);
    wr(8'h1C, 32'd1);
    wr(8'h20, (32'd1 << 26) | 32'd1);
    wr(8'h18, 32'h00F0_0002);
    rd(8'h18, 32'h00F0_0002, "R2 panel readback");
    idle_check("R7 inverted idle levels");
    set_en(1'b1);
    repeat (18000) @(posedge clk);
    set_en(1'b0);
    idle_check("R10 inverted idle after drop");
    wr(8'h40, 32'h2);

    // Scenario C: divide by 2, interrupt enabled, clear collides with set
    wr(8'h04, (32'd4 << 20) | 32'd64);
    wr(8'h1C, (32'd1 << 26) | (32'd2 << 8));
    wr(8'h18, 32'h0000_0001);
    wr(8'h3C, 32'h2);
    rd(8'h3C, 32'h2, "R2 enable readback");
    set_en(1'b1);
    forever begin
      @(posedge clk); #1;
      if (mdiv == f_pcd() && mh == f_htot() - 1 && mv == f_vact() - 1) break;
    end
    reg_wr = 1'b1; reg_addr = 8'h40; reg_wdata = 32'h2;
    @(posedge clk); #1 reg_wr = 1'b0;
    @(negedge clk);
    check(irq_o == 1'b1, "R8 set beats simultaneous clear", 32'(irq_o), 32'd1);
    check(reg_rdata == 32'h2, "R8 status after collision", reg_rdata, 32'h2);
    wr(8'h40, 32'h2);
    @(negedge clk);
    check(irq_o == 1'b0, "R9 irq drops after clear", 32'(irq_o), 32'd0);
    wr(8'h3C, 32'h0);
    repeat (11000) @(posedge clk);
    rd(8'h40, 32'h2, "R8 status set again");
    @(negedge clk);
    check(irq_o == 1'b0, "R9 irq masked", 32'(irq_o), 32'd0);
    set_en(1'b0);
    idle_check("R10 final idle");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule